// File: doc/BRIEF.md
# Simple Dual-Port RAM with Same-Address Collision Handling

This block is a synchronous memory with one write port and one read port sharing a single clock. Each cycle it can accept one write (enable, address, data) and one read (enable, address). The read result is registered and appears one cycle after the read request, together with a valid flag.

Because both ports reach the array in the same cycle, a read and a write can target the same word at once. The block detects this case and settles it by a compile-time parameter `COLL_MODE`. With 0 the incoming write data is passed straight to the read output. With 1 the read returns the word held before the write. With 2 no check is made and the read result is undefined, driven as X in simulation. In every mode the write itself is stored.

Top module: `sdp_ram_collide`

## Requirements
- R1: While `rst_n` is low, and in the first cycle after reset, `rd_valid` is 0 and `rd_data` is all zeros.
- R2: `rd_valid` in a cycle equals the value of `rd_en` sampled at the previous rising clock edge, in every mode.
- R3: A read whose address differs from the write address of the same cycle, or that has no write beside it, returns the word last written to that address, one cycle after the request, in every mode. A write in the same cycle to another address is stored as well.
- R4: A collision exists only when `wr_en` and `rd_en` are both 1 and `rd_addr` equals `wr_addr`. Equal addresses with `wr_en` at 0 give the stored word, and a write with `rd_en` at 0 gives no read result.
- R5: With `COLL_MODE` = 0, a colliding read returns the `wr_data` of that cycle.
- R6: With `COLL_MODE` = 1, a colliding read returns the word stored at that address before the write.
- R7: With `COLL_MODE` = 2, a colliding read still sets `rd_valid`, and its data is undefined (X).
- R8: In a cycle after `rd_en` was 0, `rd_data` keeps its previous value.
- R9: A colliding write is stored in every mode. A read in the cycle after any write to its address returns the new word.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock for both ports |
| rst_n | input | 1 | Asynchronous active-low reset of the read register |
| wr_en | input | 1 | Write request |
| wr_addr | input | ADDR_W | Write address |
| wr_data | input | DATA_W | Write data |
| rd_en | input | 1 | Read request |
| rd_addr | input | ADDR_W | Read address |
| rd_valid | output | 1 | Read data valid, one cycle after `rd_en` |
| rd_data | output | DATA_W | Registered read data, held when no read |

## Verification
Every result is due exactly one clock edge after its request. A read and a write presented in cycle t give `rd_valid` and `rd_data` after edge t+1, and the new word is visible to a read issued in cycle t+1. The driver presents inputs on the falling edge and queues one expected item per cycle. The monitor takes that item 1 ns after the next rising edge. Idle cycles also queue items, so valid-low and data-hold are checked in step. Three instances with the three collision modes share the same stimulus, and each is compared with its own expectation computed from a reference array.

// File: rtl/sdp_ram_pkg.sv
`timescale 1ns/1ps
package sdp_ram_pkg;
    localparam int COLL_BYPASS = 0;
    localparam int COLL_OLD    = 1;
    localparam int COLL_NOCHK  = 2;
endpackage

// File: rtl/sdp_store.sv
`timescale 1ns/1ps
// Storage array: synchronous write, combinational read of current contents.
module sdp_store #(
    parameter int DATA_W = 16,
    parameter int ADDR_W = 5
) (
    input  logic              clk,
    input  logic              we,
    input  logic [ADDR_W-1:0] waddr,
    input  logic [DATA_W-1:0] wdata,
    input  logic [ADDR_W-1:0] raddr,
    output logic [DATA_W-1:0] rword
);
    localparam int DEPTH = 1 << ADDR_W;

    logic [DATA_W-1:0] mem_q [DEPTH];

    always_ff @(posedge clk) begin
        if (we) mem_q[waddr] <= wdata;
    end

    // Value before this cycle's write: the old word
    assign rword = mem_q[raddr];
endmodule

// File: rtl/sdp_clash.sv
`timescale 1ns/1ps
// Same-address collision detector.
module sdp_clash #(
    parameter int ADDR_W = 5
) (
    input  logic              we,
    input  logic              re,
    input  logic [ADDR_W-1:0] waddr,
    input  logic [ADDR_W-1:0] raddr,
    output logic              clash
);
    always_comb begin
        clash = we && re && (waddr == raddr);
    end
endmodule

// File: rtl/sdp_rdport.sv
`timescale 1ns/1ps
// Read output register with mode-dependent collision word.
module sdp_rdport
    import sdp_ram_pkg::*;
#(
    parameter int DATA_W    = 16,
    parameter int COLL_MODE = COLL_BYPASS
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              re,
    input  logic              clash,
    input  logic [DATA_W-1:0] stored,
    input  logic [DATA_W-1:0] wdata,
    output logic              valid,
    output logic [DATA_W-1:0] data
);
    typedef struct packed {
        logic              valid;
        logic [DATA_W-1:0] data;
    } rd_st_t;

    rd_st_t            st_d, st_q;
    logic [DATA_W-1:0] clash_word;

    generate
        if (COLL_MODE == COLL_BYPASS) begin : g_bypass
            assign clash_word = wdata;
        end else if (COLL_MODE == COLL_OLD) begin : g_old
            assign clash_word = stored;
        end else begin : g_nochk
            assign clash_word = 'x;
        end
    endgenerate

    always_comb begin
        st_d       = st_q;
        st_d.valid = re;
        if (re) begin
            st_d.data = clash ? clash_word : stored;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign valid = st_q.valid;
    assign data  = st_q.data;
endmodule

// File: rtl/sdp_ram_collide.sv
`timescale 1ns/1ps
module sdp_ram_collide
    import sdp_ram_pkg::*;
#(
    parameter int DATA_W    = 16,
    parameter int ADDR_W    = 5,
    parameter int COLL_MODE = COLL_BYPASS
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              rd_en,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic              rd_valid,
    output logic [DATA_W-1:0] rd_data
);
    logic [DATA_W-1:0] stored_word;
    logic              clash;

    sdp_store #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) store_i (
        .clk   (clk),
        .we    (wr_en),
        .waddr (wr_addr),
        .wdata (wr_data),
        .raddr (rd_addr),
        .rword (stored_word)
    );

    sdp_clash #(.ADDR_W(ADDR_W)) clash_i (
        .we    (wr_en),
        .re    (rd_en),
        .waddr (wr_addr),
        .raddr (rd_addr),
        .clash (clash)
    );

    sdp_rdport #(.DATA_W(DATA_W), .COLL_MODE(COLL_MODE)) rdport_i (
        .clk    (clk),
        .rst_n  (rst_n),
        .re     (rd_en),
        .clash  (clash),
        .stored (stored_word),
        .wdata  (wr_data),
        .valid  (rd_valid),
        .data   (rd_data)
    );
endmodule

// File: rtl/sdp_ram_collide_chk.sv
`timescale 1ns/1ps
module sdp_ram_collide_chk #(
    parameter int DATA_W    = 16,
    parameter int ADDR_W    = 5,
    parameter int COLL_MODE = 0
) (
    input logic              clk,
    input logic              rst_n,
    input logic              wr_en,
    input logic [ADDR_W-1:0] wr_addr,
    input logic [DATA_W-1:0] wr_data,
    input logic              rd_en,
    input logic [ADDR_W-1:0] rd_addr,
    input logic              rd_valid,
    input logic [DATA_W-1:0] rd_data
);
    p_valid_rise_r2: assert property (@(posedge clk) disable iff (!rst_n)
        rd_en |=> rd_valid);

    p_valid_low_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_en |=> !rd_valid);

    p_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_en |=> $stable(rd_data));

    p_bypass_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (COLL_MODE == 0 && wr_en && rd_en && wr_addr == rd_addr)
        |=> rd_data == $past(wr_data));

    p_new_word_r9: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(wr_en) && rd_en && rd_addr == $past(wr_addr)
         && !(wr_en && wr_addr == rd_addr))
        |=> rd_data == $past(wr_data, 2));
endmodule

bind sdp_ram_collide sdp_ram_collide_chk #(
    .DATA_W(DATA_W), .ADDR_W(ADDR_W), .COLL_MODE(COLL_MODE)
) chk_i (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .rd_en(rd_en), .rd_addr(rd_addr),
    .rd_valid(rd_valid), .rd_data(rd_data)
);

// File: tb/sdp_ram_collide_tb_top.sv
`timescale 1ns/1ps
module sdp_ram_collide_tb_top;
    localparam int DW = 16;
    localparam int AW = 5;
    localparam int NW = 1 << AW;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #2 clk = ~clk;

    logic          wr_en = 0, rd_en = 0;
    logic [AW-1:0] wr_addr = '0, rd_addr = '0;
    logic [DW-1:0] wr_data = '0;
    logic          vld [3];
    logic [DW-1:0] dat [3];

    sdp_ram_collide #(.DATA_W(DW), .ADDR_W(AW), .COLL_MODE(0)) dut_i (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .rd_en(rd_en), .rd_addr(rd_addr), .rd_valid(vld[0]), .rd_data(dat[0]));
    sdp_ram_collide #(.DATA_W(DW), .ADDR_W(AW), .COLL_MODE(1)) dut_old_i (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .rd_en(rd_en), .rd_addr(rd_addr), .rd_valid(vld[1]), .rd_data(dat[1]));
    sdp_ram_collide #(.DATA_W(DW), .ADDR_W(AW), .COLL_MODE(2)) dut_nc_i (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .rd_en(rd_en), .rd_addr(rd_addr), .rd_valid(vld[2]), .rd_data(dat[2]));

    typedef struct {
        logic          v;
        logic          known;
        logic [DW-1:0] d;
        string         tag;
    } exp_t;

    exp_t          q0[$], q1[$], q2[$];
    logic [DW-1:0] ref_mem [NW];
    logic [DW-1:0] last_d [3];
    logic          last_k [3];
    logic          prev_we;
    logic [AW-1:0] prev_wa;
    int checks = 0, errors = 0;
    bit done = 0;

    task automatic chk(input bit ok, input string tag, input string who,
                       input logic [DW-1:0] act, input logic [DW-1:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s actual=%h expected=%h", tag, who, act, exp);
        end
    endtask

    // Driver: one cycle of stimulus, expected item per instance queued.
    task automatic cyc(input logic we, input logic [AW-1:0] wa, input logic [DW-1:0] wd,
                       input logic re, input logic [AW-1:0] ra);
        bit clash;
        @(negedge clk);
        wr_en = we; wr_addr = wa; wr_data = wd; rd_en = re; rd_addr = ra;
        clash = we && re && (wa == ra);
        for (int m = 0; m < 3; m++) begin
            exp_t e;
            e.v = re;
            if (re) begin
                e.known = 1'b1;
                if (clash) begin
                    e.tag = (m == 0) ? "R5" : (m == 1) ? "R6" : "R7";
                    if (m == 0) e.d = wd;
                    else if (m == 1) e.d = ref_mem[ra];
                    else begin e.d = '0; e.known = 1'b0; end
                end else begin
                    e.d = ref_mem[ra];
                    if (wa == ra) e.tag = "R4";
                    else if (prev_we && prev_wa == ra) e.tag = "R9";
                    else e.tag = "R3";
                end
            end else begin
                e.d = last_d[m]; e.known = last_k[m];
                e.tag = "R8";
            end
            last_d[m] = e.d; last_k[m] = e.known;
            if (m == 0) q0.push_back(e);
            else if (m == 1) q1.push_back(e);
            else q2.push_back(e);
        end
        if (we) ref_mem[wa] = wd;
        prev_we = we; prev_wa = wa;
    endtask

    task automatic cmp(input exp_t e, input int m);
        string who;
        who = (m == 0) ? "bypass" : (m == 1) ? "old" : "nochk";
        chk(vld[m] == e.v, "R2", who, {15'd0, vld[m]}, {15'd0, e.v});
        if (e.known) chk(dat[m] == e.d, e.tag, who, dat[m], e.d);
    endtask

    // Monitor: compare 1 ns after each rising edge.
    initial begin
        forever begin
            @(posedge clk);
            #1;
            if (q0.size() > 0) cmp(q0.pop_front(), 0);
            if (q1.size() > 0) cmp(q1.pop_front(), 1);
            if (q2.size() > 0) cmp(q2.pop_front(), 2);
        end
    end

    initial begin
        #(4 * 100000);
        if (!done) begin
            errors++;
            $display("FAIL watchdog R2 actual=hung expected=done");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        for (int m = 0; m < 3; m++) begin last_d[m] = '0; last_k[m] = 1'b1; end
        prev_we = 0; prev_wa = '0;
        repeat (3) @(posedge clk);
        #1;
        for (int m = 0; m < 3; m++) begin
            chk(vld[m] == 1'b0, "R1", "reset", {15'd0, vld[m]}, '0);
            chk(dat[m] == '0, "R1", "reset", dat[m], '0);
        end
        @(negedge clk);
        rst_n = 1'b1;
        #1;
        for (int m = 0; m < 3; m++) chk(vld[m] == 1'b0, "R1", "post", {15'd0, vld[m]}, '0);

        // Fill every word
        for (int a = 0; a < NW; a++) cyc(1, a[AW-1:0], 16'h1000 + 16'(a * 7), 0, '0);
        // Plain reads of every word (R3)
        for (int a = 0; a < NW; a++) cyc(0, '0, '0, 1, a[AW-1:0]);
        // Write then read on next cycle (R9)
        cyc(1, 5'd3, 16'hBEEF, 0, '0);
        cyc(0, '0, '0, 1, 5'd3);
        // Write and read different addresses together (R3)
        for (int a = 0; a < 8; a++) cyc(1, a[AW-1:0], 16'h2200 + 16'(a), 1, 5'(a + 10));
        for (int a = 0; a < 8; a++) cyc(0, '0, '0, 1, a[AW-1:0]);
        // Collisions, then read back the stored word (R5 R6 R7 R9)
        cyc(1, 5'd7, 16'hA5A5, 1, 5'd7);
        cyc(0, '0, '0, 1, 5'd7);
        cyc(1, 5'd31, 16'h5A5A, 1, 5'd31);
        cyc(0, '0, '0, 0, '0);
        cyc(0, '0, '0, 1, 5'd31);
        // Back-to-back collisions at one address
        cyc(1, 5'd12, 16'h0001, 1, 5'd12);
        cyc(1, 5'd12, 16'h0002, 1, 5'd12);
        cyc(1, 5'd12, 16'h0003, 1, 5'd12);
        cyc(0, '0, '0, 1, 5'd12);
        // Write with read disabled at same address: no result, data held (R4 R8)
        cyc(1, 5'd20, 16'hC0DE, 0, 5'd20);
        cyc(0, '0, '0, 0, '0);
        // Equal addresses, write disabled: stored word (R4)
        cyc(0, 5'd20, 16'hFFFF, 1, 5'd20);
        // Idle hold (R8)
        repeat (4) cyc(0, '0, '0, 0, '0);
        // Collision interleaved with other reads
        for (int a = 0; a < 6; a++) begin
            cyc(1, a[AW-1:0], 16'h7700 + 16'(a), 1, a[AW-1:0]);
            cyc(1, 5'(a + 16), 16'h6600 + 16'(a), 1, a[AW-1:0]);
        end
        cyc(0, '0, '0, 0, '0);
        repeat (3) @(posedge clk);
        #2;
        done = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule